// File: doc/BRIEF.md
# Four-timeslot TDM channel port

The block sits between a framed serial time-division stream and the parallel channel registers of a subscriber line interface. A bit clock paces the stream and a one-cycle frame pulse marks its first bit. Each frame is 32 bits long and holds four 8-bit timeslots that always appear in the same order. Slot 0 is the D-channel, slot 1 the C-channel (control, which holds the housekeeping bit), slot 2 the B1 channel and slot 3 the B2 channel. On the receive side the block takes the stream apart into four byte registers and pulses a strobe once a full frame has arrived. On the transmit side it serialises four byte registers into the outgoing stream.

The two kinds of channel use opposite bit orders. D and C bytes travel least significant bit first. B bytes travel most significant bit first. A rate input chooses between two line formats. The high-rate format uses all four slots. The low-rate format carries only D-channel bit 0 and the B1 byte, and every other bit position counts as unused.

A small state machine follows the frame position. ST_IDLE is the state after reset, before any frame pulse. ST_D, ST_C, ST_B1 and ST_B2 each cover eight bit positions.
- A frame pulse in any state forces the current cycle to be ST_D position 0.
- The machine moves ST_D to ST_C to ST_B1 to ST_B2 after the eighth bit of each slot.
- After the last bit of ST_B2 it wraps to ST_D without waiting for a pulse (flywheel).
- It never returns to ST_IDLE except through reset.

Top module: `tdm_chan_port`

## Requirements
- R1: After reset, tx_sdata is 1, rx_valid is 0 and all four receive registers are 8'h00. Until the first frame pulse, tx_sdata stays 1 and rx_valid stays 0 whatever rx_sdata does.
- R2: The cycle in which frame_pulse is high carries frame bit 0. Frame bits 0-7 belong to D, 8-15 to C, 16-23 to B1 and 24-31 to B2.
- R3: D and C bytes are carried bit 0 first. Byte bit i is frame bit (slot*8 + i).
- R4: B1 and B2 bytes are carried bit 7 first. Byte bit i is frame bit (slot*8 + 7 - i).
- R5: The four receive registers change only together. rx_valid is high for exactly one cycle, the cycle after frame bit 31, and the registers show the new frame in that cycle.
- R6: Frame bit k appears on tx_sdata in the cycle k+1 counted from the pulse cycle (pulse cycle = 0). The transmitted frame uses tx_d, tx_c, tx_b1, tx_b2 and rate_hi as they were in the pulse cycle. Changes after that cycle do not affect the frame.
- R7: With rate_hi = 0 (low rate, sampled at the pulse), only D bit 0 and the B1 byte are used. In that case:
  - tx_sdata is 1 on D bits 1-7 and on all of C and B2.
  - The receive side reports rx_d = {7'b1111111, D0}, rx_c = 8'hFF and rx_b2 = 8'hFF, whatever arrived in those positions.
- R8: With rate_hi = 1 (high rate), all 32 bit positions carry data in both directions, including the C-channel byte with its housekeeping bit.
- R9: A frame pulse before bit 31 restarts the frame at bit 0. The cut-short frame produces no rx_valid.
- R10: Without a new pulse, a new frame starts right after bit 31. It reuses the transmit values and rate latched at the last pulse, and it strobes rx_valid normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| frame_pulse | input | 1 | One-cycle marker of frame bit 0 |
| rate_hi | input | 1 | 1 = high-rate format, 0 = low-rate format; sampled at the pulse |
| rx_sdata | input | 1 | Receive serial data, one bit per clock |
| tx_d | input | 8 | D-channel byte to send |
| tx_c | input | 8 | C-channel byte to send |
| tx_b1 | input | 8 | B1 byte to send |
| tx_b2 | input | 8 | B2 byte to send |
| rx_d | output | 8 | Received D-channel byte |
| rx_c | output | 8 | Received C-channel byte |
| rx_b1 | output | 8 | Received B1 byte |
| rx_b2 | output | 8 | Received B2 byte |
| rx_valid | output | 1 | One-cycle strobe: receive registers hold a new frame |
| tx_sdata | output | 1 | Transmit serial data, one bit per clock |

## Verification
Receive and transmit are each swept in both formats with a walking one over all 32 frame bit positions, the opposite direction carrying a walking zero. A misplaced slot, a reversed bit order or a wrongly masked unused bit therefore shows up as a single wrong bit at a known position. Pseudo-random frames with alternating rate check that the format follows the pulse-time sample. In every frame the transmit bytes and the rate are changed mid-frame, which separates sampling at the pulse from reading the inputs live. A cut-short frame followed by a realigning pulse, and a frame with no pulse at all, test the restart and flywheel paths against the strobe timing.

// File: rtl/tdm_pkg.sv
package tdm_pkg;
    localparam int SLOT_W  = 8;
    localparam int N_SLOTS = 4;
    localparam int POS_W   = $clog2(SLOT_W);

    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_D    = 3'd1,
        ST_C    = 3'd2,
        ST_B1   = 3'd3,
        ST_B2   = 3'd4
    } slot_st_t;

    // position within the byte for a given slot and serial position
    function automatic logic [POS_W-1:0] byte_bit(input slot_st_t st,
                                                  input logic [POS_W-1:0] pos);
        logic [POS_W-1:0] r;
        r = pos;
        if (st == ST_B1 || st == ST_B2)
            r = POS_W'(SLOT_W - 1) - pos;
        return r;
    endfunction

    // whether a serial position carries data in the selected format
    function automatic logic pos_used(input slot_st_t st,
                                      input logic [POS_W-1:0] pos,
                                      input logic hi);
        logic u;
        u = 1'b0;
        unique case (st)
            ST_IDLE: u = 1'b0;
            ST_D:    u = hi || (pos == '0);
            ST_C:    u = hi;
            ST_B1:   u = 1'b1;
            ST_B2:   u = hi;
        endcase
        return u;
    endfunction
endpackage

// File: rtl/tdm_frame_ctrl.sv
module tdm_frame_ctrl
    import tdm_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             frame_pulse,
    input  logic             rate_hi,
    output slot_st_t         cur_st,
    output logic [POS_W-1:0] cur_pos,
    output logic             frame_end,
    output logic             rate_eff,
    output logic             rate_lat,
    output logic             synced
);
    localparam logic [POS_W-1:0] LAST_POS = POS_W'(SLOT_W - 1);

    slot_st_t         state, state_n;
    logic [POS_W-1:0] pos, pos_n;
    logic             rate_r;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            pos    <= '0;
            rate_r <= 1'b0;
        end else begin
            state <= state_n;
            pos   <= pos_n;
            if (frame_pulse)
                rate_r <= rate_hi;
        end
    end

    // outputs: position of the current cycle
    always_comb begin
        if (frame_pulse) begin
            cur_st  = ST_D;
            cur_pos = '0;
        end else begin
            cur_st  = state;
            cur_pos = pos;
        end
        rate_eff  = frame_pulse ? rate_hi : rate_r;
        rate_lat  = rate_r;
        synced    = (state != ST_IDLE);
        frame_end = (cur_st == ST_B2) && (cur_pos == LAST_POS);
    end

    // next state
    always_comb begin
        state_n = cur_st;
        pos_n   = cur_pos;
        if (cur_st != ST_IDLE) begin
            if (cur_pos == LAST_POS) begin
                pos_n = '0;
                unique case (cur_st)
                    ST_IDLE: state_n = ST_IDLE;
                    ST_D:    state_n = ST_C;
                    ST_C:    state_n = ST_B1;
                    ST_B1:   state_n = ST_B2;
                    ST_B2:   state_n = ST_D;
                endcase
            end else begin
                pos_n = cur_pos + 1'b1;
            end
        end
    end
endmodule

// File: rtl/tdm_rx_deint.sv
module tdm_rx_deint
    import tdm_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  slot_st_t          cur_st,
    input  logic [POS_W-1:0]  cur_pos,
    input  logic              frame_end,
    input  logic              rate_eff,
    input  logic              rx_sdata,
    output logic [SLOT_W-1:0] rx_d,
    output logic [SLOT_W-1:0] rx_c,
    output logic [SLOT_W-1:0] rx_b1,
    output logic [SLOT_W-1:0] rx_b2,
    output logic              rx_valid
);
    logic [SLOT_W-1:0] work [N_SLOTS];
    logic [SLOT_W-1:0] assembled [N_SLOTS];
    logic [POS_W-1:0]  bidx;
    logic              bitv;

    always_comb begin
        bidx = byte_bit(cur_st, cur_pos);
        bitv = pos_used(cur_st, cur_pos, rate_eff) ? rx_sdata : 1'b1;
    end

    for (genvar g = 0; g < N_SLOTS; g++) begin : g_slot
        localparam slot_st_t G_ST = slot_st_t'(g + 1);

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                work[g] <= '0;
            else if (cur_st == G_ST)
                work[g][bidx] <= bitv;
        end

        // include the bit arriving in this cycle
        always_comb begin
            assembled[g] = work[g];
            if (cur_st == G_ST)
                assembled[g][bidx] = bitv;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rx_d     <= '0;
            rx_c     <= '0;
            rx_b1    <= '0;
            rx_b2    <= '0;
            rx_valid <= 1'b0;
        end else begin
            rx_valid <= frame_end;
            if (frame_end) begin
                rx_d  <= assembled[0];
                rx_c  <= assembled[1];
                rx_b1 <= assembled[2];
                rx_b2 <= assembled[3];
            end
        end
    end
endmodule

// File: rtl/tdm_tx_ser.sv
module tdm_tx_ser
    import tdm_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_pulse,
    input  slot_st_t          cur_st,
    input  logic [POS_W-1:0]  cur_pos,
    input  logic              rate_eff,
    input  logic [SLOT_W-1:0] tx_d,
    input  logic [SLOT_W-1:0] tx_c,
    input  logic [SLOT_W-1:0] tx_b1,
    input  logic [SLOT_W-1:0] tx_b2,
    output logic              tx_sdata
);
    logic [SLOT_W-1:0] lat_d, lat_c, lat_b1, lat_b2;
    logic [SLOT_W-1:0] sel;
    logic              tx_next;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lat_d  <= '0;
            lat_c  <= '0;
            lat_b1 <= '0;
            lat_b2 <= '0;
        end else if (frame_pulse) begin
            lat_d  <= tx_d;
            lat_c  <= tx_c;
            lat_b1 <= tx_b1;
            lat_b2 <= tx_b2;
        end
    end

    always_comb begin
        sel = '1;
        unique case (cur_st)
            ST_IDLE: sel = '1;
            ST_D:    sel = frame_pulse ? tx_d  : lat_d;
            ST_C:    sel = frame_pulse ? tx_c  : lat_c;
            ST_B1:   sel = frame_pulse ? tx_b1 : lat_b1;
            ST_B2:   sel = frame_pulse ? tx_b2 : lat_b2;
        endcase
        if (pos_used(cur_st, cur_pos, rate_eff))
            tx_next = sel[byte_bit(cur_st, cur_pos)];
        else
            tx_next = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            tx_sdata <= 1'b1;
        else
            tx_sdata <= tx_next;
    end
endmodule

// File: rtl/tdm_chan_port.sv
module tdm_chan_port
    import tdm_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_pulse,
    input  logic              rate_hi,
    input  logic              rx_sdata,
    input  logic [SLOT_W-1:0] tx_d,
    input  logic [SLOT_W-1:0] tx_c,
    input  logic [SLOT_W-1:0] tx_b1,
    input  logic [SLOT_W-1:0] tx_b2,
    output logic [SLOT_W-1:0] rx_d,
    output logic [SLOT_W-1:0] rx_c,
    output logic [SLOT_W-1:0] rx_b1,
    output logic [SLOT_W-1:0] rx_b2,
    output logic              rx_valid,
    output logic              tx_sdata
);
    slot_st_t         cur_st;
    logic [POS_W-1:0] cur_pos;
    logic             frame_end;
    logic             rate_eff;
    logic             rate_lat;
    logic             synced;

    tdm_frame_ctrl u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .frame_pulse (frame_pulse),
        .rate_hi     (rate_hi),
        .cur_st      (cur_st),
        .cur_pos     (cur_pos),
        .frame_end   (frame_end),
        .rate_eff    (rate_eff),
        .rate_lat    (rate_lat),
        .synced      (synced)
    );

    tdm_rx_deint u_rx (
        .clk       (clk),
        .rst_n     (rst_n),
        .cur_st    (cur_st),
        .cur_pos   (cur_pos),
        .frame_end (frame_end),
        .rate_eff  (rate_eff),
        .rx_sdata  (rx_sdata),
        .rx_d      (rx_d),
        .rx_c      (rx_c),
        .rx_b1     (rx_b1),
        .rx_b2     (rx_b2),
        .rx_valid  (rx_valid)
    );

    tdm_tx_ser u_tx (
        .clk         (clk),
        .rst_n       (rst_n),
        .frame_pulse (frame_pulse),
        .cur_st      (cur_st),
        .cur_pos     (cur_pos),
        .rate_eff    (rate_eff),
        .tx_d        (tx_d),
        .tx_c        (tx_c),
        .tx_b1       (tx_b1),
        .tx_b2       (tx_b2),
        .tx_sdata    (tx_sdata)
    );
endmodule

// File: rtl/tdm_chan_port_chk.sv
module tdm_chan_port_chk
    import tdm_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              frame_pulse,
    input logic              synced,
    input logic              rate_lat,
    input logic              rx_valid,
    input logic              tx_sdata,
    input logic [SLOT_W-1:0] rx_d,
    input logic [SLOT_W-1:0] rx_c,
    input logic [SLOT_W-1:0] rx_b1,
    input logic [SLOT_W-1:0] rx_b2
);
    // R5
    valid_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> !rx_valid);

    // R5
    regs_together_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable({rx_d, rx_c, rx_b1, rx_b2}) |-> rx_valid);

    // R9
    pulse_no_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_pulse |=> !rx_valid);

    // R1
    idle_tx_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!synced && !frame_pulse) |=> tx_sdata);

    // R7
    low_rate_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && !rate_lat) |->
            (rx_c == '1 && rx_b2 == '1 && rx_d[SLOT_W-1:1] == '1));
endmodule

bind tdm_chan_port tdm_chan_port_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .frame_pulse (frame_pulse),
    .synced      (synced),
    .rate_lat    (rate_lat),
    .rx_valid    (rx_valid),
    .tx_sdata    (tx_sdata),
    .rx_d        (rx_d),
    .rx_c        (rx_c),
    .rx_b1       (rx_b1),
    .rx_b2       (rx_b2)
);

// File: tb/tb_tdm_chan_port.sv
module tb_tdm_chan_port;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 200000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       frame_pulse = 1'b0;
    logic       rate_hi = 1'b1;
    logic       rx_sdata = 1'b0;
    logic [7:0] tx_d = '0, tx_c = '0, tx_b1 = '0, tx_b2 = '0;
    logic [7:0] rx_d, rx_c, rx_b1, rx_b2;
    logic       rx_valid, tx_sdata;

    tdm_chan_port dut (
        .clk(clk), .rst_n(rst_n), .frame_pulse(frame_pulse), .rate_hi(rate_hi),
        .rx_sdata(rx_sdata), .tx_d(tx_d), .tx_c(tx_c), .tx_b1(tx_b1), .tx_b2(tx_b2),
        .rx_d(rx_d), .rx_c(rx_c), .rx_b1(rx_b1), .rx_b2(rx_b2),
        .rx_valid(rx_valid), .tx_sdata(tx_sdata)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    // state carried from one frame to the next
    bit          have_prev = 0;
    bit          prev_vexp = 0;
    int          prev_len  = 0;
    logic [31:0] prev_exp, prev_got;
    logic [31:0] prev_rx;
    string       prev_tag;
    logic [7:0]  ld = '0, lc = '0, lb1 = '0, lb2 = '0;
    bit          lrate = 0;

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s act=%h exp=%h", tag, what, act, exp);
        end
    endtask

    // serial frame from bytes (R2, R3, R4); unused positions forced to 1 (R7)
    function automatic logic [31:0] build(input logic [7:0] d, c, b1, b2, input bit hi);
        logic [31:0] f;
        for (int k = 0; k < 32; k++) begin
            int s = k / 8;
            int p = k % 8;
            bit used;
            logic v;
            case (s)
                0: begin used = hi || (p == 0); v = d[p]; end
                1: begin used = hi;             v = c[p]; end
                2: begin used = 1'b1;           v = b1[7-p]; end
                default: begin used = hi;       v = b2[7-p]; end
            endcase
            f[k] = used ? v : 1'b1;
        end
        return f;
    endfunction

    function automatic logic [31:0] rx_expect(input logic [7:0] d, c, b1, b2, input bit hi);
        if (hi) return {b2, b1, c, d};
        return {8'hFF, b1, 8'hFF, {7'h7F, d[0]}};
    endfunction

    // sample point in the first cycle after the previous frame
    task automatic finish_prev();
        logic [31:0] mask;
        if (have_prev) begin
            prev_got[prev_len-1] = tx_sdata;
            mask = (prev_len == 32) ? 32'hFFFF_FFFF : ((32'd1 << prev_len) - 32'd1);
            check(((prev_got ^ prev_exp) & mask) == 0, {"R6 ", prev_tag}, "tx frame",
                  prev_got & mask, prev_exp & mask);
            check(rx_valid == prev_vexp, {"R5 ", prev_tag}, "rx_valid after frame",
                  32'(rx_valid), 32'(prev_vexp));
            if (prev_vexp)
                check({rx_b2, rx_b1, rx_c, rx_d} == prev_rx, prev_tag, "rx regs",
                      {rx_b2, rx_b1, rx_c, rx_d}, prev_rx);
        end
    endtask

    task automatic run_frame(input bit fp, input int len, input bit rate,
                             input logic [7:0] rd, rc, rb1, rb2,
                             input logic [7:0] td, tc, tb1, tb2, input string tag);
        logic [31:0] rxf;
        logic [31:0] got;
        rxf = build(rd, rc, rb1, rb2, 1'b1);
        got = '0;
        if (fp) begin
            ld = td; lc = tc; lb1 = tb1; lb2 = tb2; lrate = rate;
        end
        for (int k = 0; k < len; k++) begin
            @(negedge clk);
            if (k == 0) begin
                finish_prev();
            end else begin
                got[k-1] = tx_sdata;
                check(rx_valid == 1'b0, "R5", "rx_valid mid frame", 32'(rx_valid), 32'd0);
            end
            frame_pulse = fp && (k == 0);
            rx_sdata    = rxf[k];
            if (k == 0) begin
                tx_d = td; tx_c = tc; tx_b1 = tb1; tx_b2 = tb2; rate_hi = rate;
            end
            if (k == 5) begin
                // R6: changes after the pulse must not reach the frame
                tx_d = ~td; tx_c = ~tc; tx_b1 = ~tb1; tx_b2 = ~tb2; rate_hi = ~rate;
            end
        end
        have_prev = 1;
        prev_got  = got;
        prev_len  = len;
        prev_exp  = build(ld, lc, lb1, lb2, lrate);
        prev_vexp = (len == 32);
        prev_rx   = rx_expect(rd, rc, rb1, rb2, lrate);
        prev_tag  = {tag, lrate ? " R8" : " R7"};
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] lfsr;
        logic [31:0] w;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(tx_sdata == 1'b1, "R1", "tx_sdata after reset", 32'(tx_sdata), 32'd1);
        check(rx_valid == 1'b0, "R1", "rx_valid after reset", 32'(rx_valid), 32'd0);
        check({rx_b2, rx_b1, rx_c, rx_d} == 32'd0, "R1", "rx regs after reset",
              {rx_b2, rx_b1, rx_c, rx_d}, 32'd0);
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            check(tx_sdata == 1'b1 && rx_valid == 1'b0, "R1", "idle before pulse",
                  {30'd0, tx_sdata, rx_valid}, 32'd2);
            rx_sdata = i[1] ^ i[0];
        end

        // walking one on receive, walking zero on transmit, both formats
        for (int r = 1; r >= 0; r--) begin
            for (int i = 0; i < 32; i++) begin
                w = 32'd1 << i;
                run_frame(1'b1, 32, r[0], w[7:0], w[15:8], w[23:16], w[31:24],
                          ~w[7:0], ~w[15:8], ~w[23:16], ~w[31:24], "R2 R3 R4");
            end
        end

        // pseudo-random frames with alternating rate
        lfsr = 32'hACE1_2357;
        for (int i = 0; i < 40; i++) begin
            logic [31:0] a, b;
            lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
            a = lfsr * 32'd2654435761;
            b = lfsr ^ 32'h5A5A_C3C3;
            run_frame(1'b1, 32, i[0] ^ i[2], a[7:0], a[15:8], a[23:16], a[31:24],
                      b[7:0], b[15:8], b[23:16], b[31:24], "R2 R6");
        end

        // cut-short frame, then realignment
        run_frame(1'b1, 11, 1'b1, 8'h3C, 8'hC3, 8'h99, 8'h66,
                  8'h12, 8'h34, 8'h56, 8'h78, "R9");
        run_frame(1'b1, 32, 1'b1, 8'hA5, 8'h5A, 8'h0F, 8'hF0,
                  8'h81, 8'h42, 8'h24, 8'h18, "R9");

        // flywheel frames without a pulse, high then low rate
        run_frame(1'b0, 32, 1'b0, 8'h6E, 8'hB7, 8'h2D, 8'hD2,
                  8'h00, 8'hFF, 8'h00, 8'hFF, "R10");
        run_frame(1'b1, 32, 1'b0, 8'hFE, 8'h11, 8'hC5, 8'h77,
                  8'hE4, 8'hAB, 8'h1D, 8'h90, "R7");
        run_frame(1'b0, 32, 1'b1, 8'h01, 8'hEE, 8'h3A, 8'h5C,
                  8'h00, 8'h00, 8'h00, 8'h00, "R10");

        @(negedge clk);
        finish_prev();
        frame_pulse = 1'b0;

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule